// File: doc/BRIEF.md
# Linked-Descriptor Cyclic DMA Channel

This block is one channel of a small DMA engine. Software points it at a 16-byte descriptor in memory and enables it. The channel reads the descriptor's four words, then moves the described byte count one 32-bit word at a time. Each word is read from the source address and written to the destination address, and each address side either steps by four or stays fixed. This lets one side track a buffer in memory while the other stays on a peripheral data register.

When a descriptor's count runs out, the channel flags completion and can raise an interrupt. In chain mode it then loads the descriptor named by the current one's next pointer. A ring whose last entry points back to the first therefore streams forever, which suits audio-style double buffering. Software can pause the channel between beats, resume it, or abort it at once. A single valid/ready memory port carries both the descriptor reads and the data beats.

Top module: `cdma_chan`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `mem_req` is low.
- R2: Register offsets are: byte count 0x00, source 0x10, destination 0x20, next pointer 0x30, control 0x40, current descriptor 0x70, interrupt mask 0x80, interrupt status 0xA0. While the channel is idle, count, source, destination and next pointer are writable and read back what was written.
- R3: Writing control with bit 12 (enable) and bit 13 (fetch) set makes the channel read four words at the next-pointer address with its low 4 bits cleared. The words are read in this order: byte count, source, destination, next pointer. The current-descriptor register then reads that aligned address.
- R4: Each beat reads one word at the source address and writes it unchanged to the destination address. Each beat lowers the byte count by 4.
- R5: Control bits [3:2] set the source address mode and bits [5:4] set the destination address mode. Code 0 steps the address by 4 after each beat. Code 2 keeps it fixed.
- R6: Interrupt status bit 0 sets on the beat that brings the count to zero. `irq` equals status bit 0 AND mask bit 0. Writing status bit 0 as 0 clears it, and writing it as 1 has no effect.
- R7: With control bit 9 (chain) set, completion makes the channel fetch the descriptor at the loaded next pointer and continue, so a closed ring repeats. With bit 9 clear the channel stops, and control bit 14 (active) reads 0.
- R8: Clearing the enable bit while a transfer runs stops the channel at the next beat boundary. No memory requests follow, and active stays 1. Setting enable again resumes from the same count and addresses.
- R9: A control write with bit 20 set forces enable to 0 and returns the channel to idle on that clock edge. A request in flight is dropped, and active reads 0 in the next cycle.
- R10: Writes to count, source, destination or next pointer are ignored while active is 1.
- R11: A descriptor count above MAX_BYTES is loaded as MAX_BYTES.
- R12: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until `mem_ready` is seen, unless an abort occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` on a read |
| irq | output | 1 | Descriptor completion interrupt |

## Verification
The bench builds the channel with MAX_BYTES set to 64 rather than the default 65536. A descriptor asking for 4096 bytes is therefore clipped after 16 beats, and the clamp can be observed in a short run. All other tests use counts of 32 bytes or less, well under either limit. From the chained test onward the memory stalls every third cycle, which keeps requests waiting across clock edges.

// File: rtl/cdma_pkg.sv
// Package: shared state encoding, register offsets and control bit
// positions for the descriptor DMA channel.
package cdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_HOLD
    } eng_state_t;

    localparam logic [7:0] OFS_COUNT = 8'h00;
    localparam logic [7:0] OFS_SRC   = 8'h10;
    localparam logic [7:0] OFS_DST   = 8'h20;
    localparam logic [7:0] OFS_NEXT  = 8'h30;
    localparam logic [7:0] OFS_CTRL  = 8'h40;
    localparam logic [7:0] OFS_CUR   = 8'h70;
    localparam logic [7:0] OFS_MASK  = 8'h80;
    localparam logic [7:0] OFS_STAT  = 8'hA0;

    localparam int CB_CHAIN  = 9;
    localparam int CB_ENABLE = 12;
    localparam int CB_FETCH  = 13;
    localparam int CB_ACTIVE = 14;
    localparam int CB_ABORT  = 20;

    // stored control bits: address modes, chain, enable
    localparam logic [31:0] CTRL_KEEP = 32'h0000_123C;

    // mode code with bit 1 set holds the address, otherwise step one word
    function automatic logic [31:0] step_addr(input logic [31:0] a, input logic [1:0] mode);
        return mode[1] ? a : a + 32'd4;
    endfunction

endpackage

// File: rtl/cdma_ctrl_regs.sv
// Module: cdma_ctrl_regs
// Holds control, interrupt mask and interrupt status. Turns control writes
// into enable/chain/mode levels, a pending fetch request and an abort pulse.
// Assumes the engine pulses fetch_take_i when it starts a fetch and done_i
// on the beat that empties the count.
module cdma_ctrl_regs
    import cdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    input  logic        active_i,
    input  logic        fetch_take_i,
    input  logic        done_i,
    output logic        enable_o,
    output logic        chain_o,
    output logic [1:0]  src_mode_o,
    output logic [1:0]  dst_mode_o,
    output logic        fetch_req_o,
    output logic        abort_o,
    output logic [31:0] ctrl_rd_o,
    output logic        imask_o,
    output logic        istat_o,
    output logic        irq_o
);

    logic [31:0] ctrl_q;
    logic        fetch_q;
    logic        imask_q;
    logic        istat_q;
    logic        wr_ctrl;
    logic        wr_mask;
    logic        wr_stat;

    assign wr_ctrl = wr_en && (addr == OFS_CTRL);
    assign wr_mask = wr_en && (addr == OFS_MASK);
    assign wr_stat = wr_en && (addr == OFS_STAT);
    assign abort_o = wr_ctrl && wdata[CB_ABORT];

    // stored control bits; an abort write always leaves enable cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wdata & CTRL_KEEP;
            if (wdata[CB_ABORT]) ctrl_q[CB_ENABLE] <= 1'b0;
        end
    end

    // fetch request: set by a control write, consumed by the engine, dropped on abort
    always_ff @(posedge clk) begin
        if (!rst_n)                          fetch_q <= 1'b0;
        else if (abort_o)                    fetch_q <= 1'b0;
        else if (wr_ctrl && wdata[CB_FETCH]) fetch_q <= 1'b1;
        else if (fetch_take_i)               fetch_q <= 1'b0;
    end

    // interrupt mask bit
    always_ff @(posedge clk) begin
        if (!rst_n)       imask_q <= 1'b0;
        else if (wr_mask) imask_q <= wdata[0];
    end

    // completion status: hardware set wins over a software clear
    always_ff @(posedge clk) begin
        if (!rst_n)                     istat_q <= 1'b0;
        else if (done_i)                istat_q <= 1'b1;
        else if (wr_stat && !wdata[0])  istat_q <= 1'b0;
    end

    assign enable_o    = ctrl_q[CB_ENABLE];
    assign chain_o     = ctrl_q[CB_CHAIN];
    assign src_mode_o  = ctrl_q[3:2];
    assign dst_mode_o  = ctrl_q[5:4];
    assign fetch_req_o = fetch_q;
    assign imask_o     = imask_q;
    assign istat_o     = istat_q;
    assign irq_o       = istat_q && imask_q;

    always_comb begin
        ctrl_rd_o            = ctrl_q;
        ctrl_rd_o[CB_FETCH]  = fetch_q;
        ctrl_rd_o[CB_ACTIVE] = active_i;
    end

    a_r6_status_sets: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> istat_q);
    a_r6_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !wdata[0] && !done_i) |=> !istat_q);
    a_r9_abort_disables: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !enable_o && !fetch_req_o);

endmodule

// File: rtl/cdma_engine.sv
// Module: cdma_engine
// Sequencer for one channel: four-word descriptor fetch, then read/write
// beats of one 32-bit word each, then completion and an optional chain
// fetch. Owns the live count, source, destination, next and current
// registers. Assumes descriptor counts are non-zero multiples of 4.
module cdma_engine
    import cdma_pkg::*;
#(
    parameter int MAX_BYTES = 65536
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_we,
    input  logic [7:0]          sw_addr,
    input  logic [31:0]         sw_wdata,
    input  logic                enable_i,
    input  logic                chain_i,
    input  logic [1:0]          src_mode_i,
    input  logic [1:0]          dst_mode_i,
    input  logic                fetch_req_i,
    input  logic                abort_i,
    output logic                mem_req_o,
    output logic                mem_we_o,
    output logic [31:0]         mem_addr_o,
    output logic [31:0]         mem_wdata_o,
    input  logic                mem_ready_i,
    input  logic [31:0]         mem_rdata_i,
    output logic                active_o,
    output logic                fetch_take_o,
    output logic                done_o,
    output logic [$clog2(MAX_BYTES):0] cnt_o,
    output logic [31:0]         src_o,
    output logic [31:0]         dst_o,
    output logic [31:0]         nxt_o,
    output logic [31:0]         cur_o
);

    localparam int CNT_W = $clog2(MAX_BYTES) + 1;
    localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(MAX_BYTES);
    localparam logic [CNT_W-1:0] BEAT_CNT = CNT_W'(4);

    eng_state_t       state_q;
    logic [1:0]       widx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      src_q, dst_q, nxt_q, cur_q, dbuf_q;
    logic             hs_ok;

    // count limit applied to every load of the count register
    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [31:0] v);
        return (v > 32'(MAX_BYTES)) ? MAX_CNT : v[CNT_W-1:0];
    endfunction

    assign mem_req_o    = (state_q == ST_FETCH) || (state_q == ST_READ) || (state_q == ST_WRITE);
    assign mem_we_o     = (state_q == ST_WRITE);
    assign mem_wdata_o  = dbuf_q;
    assign hs_ok        = mem_req_o && mem_ready_i && !abort_i;
    assign active_o     = (state_q != ST_IDLE);
    assign fetch_take_o = (state_q == ST_IDLE) && enable_i && fetch_req_i && !abort_i;
    assign done_o       = (state_q == ST_WRITE) && hs_ok && (cnt_q <= BEAT_CNT);

    // address for the current request
    always_comb begin
        case (state_q)
            ST_FETCH: mem_addr_o = {cur_q[31:4], widx_q, 2'b00};
            ST_WRITE: mem_addr_o = dst_q;
            default:  mem_addr_o = src_q;
        endcase
    end

    // channel sequencing; abort returns to idle from any state
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (fetch_take_o) state_q <= ST_FETCH;
                ST_FETCH: if (hs_ok && widx_q == 2'd3) state_q <= enable_i ? ST_READ : ST_HOLD;
                ST_READ:  if (hs_ok) state_q <= ST_WRITE;
                ST_WRITE: if (hs_ok) begin
                    if (done_o)        state_q <= chain_i ? ST_FETCH : ST_IDLE;
                    else if (enable_i) state_q <= ST_READ;
                    else               state_q <= ST_HOLD;
                end
                ST_HOLD:  if (enable_i) state_q <= ST_READ;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // descriptor word index within a fetch
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i || state_q != ST_FETCH) widx_q <= 2'd0;
        else if (hs_ok)                               widx_q <= widx_q + 2'd1;
    end

    // data word carried from the read half of a beat to the write half
    always_ff @(posedge clk) begin
        if (!rst_n)                           dbuf_q <= '0;
        else if (state_q == ST_READ && hs_ok) dbuf_q <= mem_rdata_i;
    end

    // live registers: descriptor load, beat update, or software write when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            src_q <= '0;
            dst_q <= '0;
            nxt_q <= '0;
        end else if (state_q == ST_FETCH && hs_ok) begin
            case (widx_q)
                2'd0:    cnt_q <= clamp_cnt(mem_rdata_i);
                2'd1:    src_q <= mem_rdata_i;
                2'd2:    dst_q <= mem_rdata_i;
                default: nxt_q <= mem_rdata_i;
            endcase
        end else if (state_q == ST_WRITE && hs_ok) begin
            cnt_q <= (cnt_q > BEAT_CNT) ? cnt_q - BEAT_CNT : '0;
            src_q <= step_addr(src_q, src_mode_i);
            dst_q <= step_addr(dst_q, dst_mode_i);
        end else if (state_q == ST_IDLE && sw_we) begin
            case (sw_addr)
                OFS_COUNT: cnt_q <= clamp_cnt(sw_wdata);
                OFS_SRC:   src_q <= sw_wdata;
                OFS_DST:   dst_q <= sw_wdata;
                OFS_NEXT:  nxt_q <= sw_wdata;
                default:   ;
            endcase
        end
    end

    // current descriptor address, captured aligned when a fetch starts
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= '0;
        else if (fetch_take_o || (done_o && chain_i))
            cur_q <= {nxt_q[31:4], 4'h0};
    end

    assign cnt_o = cnt_q;
    assign src_o = src_q;
    assign dst_o = dst_q;
    assign nxt_o = nxt_q;
    assign cur_o = cur_q;

    a_r9_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !active_o && !mem_req_o);
    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i && !abort_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
    a_r6_done_empties: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (cnt_q == '0));
    a_r8_pause_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && state_q == ST_WRITE && hs_ok && !done_o) |=> !mem_req_o);
    a_r10_paused_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && sw_we && !abort_i) |=>
            ($stable(cnt_q) && $stable(src_q) && $stable(dst_q) && $stable(nxt_q)));
    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAX_CNT);

endmodule

// File: rtl/cdma_chan.sv
// Module: cdma_chan
// Top of one descriptor DMA channel: control/status registers, the
// transfer engine and the register read-back multiplexer.
// Assumes a single register master and a memory that answers reads in
// the cycle it raises mem_ready.
module cdma_chan
    import cdma_pkg::*;
#(
    parameter int MAX_BYTES = 65536
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    output logic        irq
);

    localparam int CNT_W = $clog2(MAX_BYTES) + 1;

    logic             enable, chain, fetch_req, abort, active, fetch_take, done;
    logic             imask, istat;
    logic [1:0]       src_mode, dst_mode;
    logic [31:0]      ctrl_rd, src, dst, nxt, cur;
    logic [CNT_W-1:0] cnt;

    cdma_ctrl_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr_en),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .active_i     (active),
        .fetch_take_i (fetch_take),
        .done_i       (done),
        .enable_o     (enable),
        .chain_o      (chain),
        .src_mode_o   (src_mode),
        .dst_mode_o   (dst_mode),
        .fetch_req_o  (fetch_req),
        .abort_o      (abort),
        .ctrl_rd_o    (ctrl_rd),
        .imask_o      (imask),
        .istat_o      (istat),
        .irq_o        (irq)
    );

    cdma_engine #(.MAX_BYTES(MAX_BYTES)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_we        (reg_wr_en),
        .sw_addr      (reg_addr),
        .sw_wdata     (reg_wdata),
        .enable_i     (enable),
        .chain_i      (chain),
        .src_mode_i   (src_mode),
        .dst_mode_i   (dst_mode),
        .fetch_req_i  (fetch_req),
        .abort_i      (abort),
        .mem_req_o    (mem_req),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .mem_ready_i  (mem_ready),
        .mem_rdata_i  (mem_rdata),
        .active_o     (active),
        .fetch_take_o (fetch_take),
        .done_o       (done),
        .cnt_o        (cnt),
        .src_o        (src),
        .dst_o        (dst),
        .nxt_o        (nxt),
        .cur_o        (cur)
    );

    // register read-back by offset
    always_comb begin
        case (reg_addr)
            OFS_COUNT: reg_rdata = {{(32-CNT_W){1'b0}}, cnt};
            OFS_SRC:   reg_rdata = src;
            OFS_DST:   reg_rdata = dst;
            OFS_NEXT:  reg_rdata = nxt;
            OFS_CTRL:  reg_rdata = ctrl_rd;
            OFS_CUR:   reg_rdata = cur;
            OFS_MASK:  reg_rdata = {31'b0, imask};
            OFS_STAT:  reg_rdata = {31'b0, istat};
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/cdma_chan_bench.sv
// Bench: scoreboard of expected memory writes, filled by driver tasks and
// drained by a monitor at every write handshake; register checks by task.
module cdma_chan_bench;

    localparam int MAXB = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;

    logic [31:0] mem [0:255];
    assign mem_rdata = mem[mem_addr[9:2]];

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    int checks = 0, fails = 0, writes_seen = 0, cyc = 0;
    bit stall_en = 0, skip_r12 = 0, pend_q = 0;
    logic [31:0] pend_addr;

    always #4 clk = ~clk;

    cdma_chan #(.MAX_BYTES(MAXB)) u_cdma_chan (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // memory model and scoreboard monitor, evaluated between clock edges
    always @(negedge clk) begin
        cyc++;
        mem_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
        #1;
        if (pend_q && !skip_r12)
            check(mem_req && mem_addr == pend_addr, "R12", "request dropped or moved", mem_addr, pend_addr);
        pend_q    = mem_req && !mem_ready;
        pend_addr = mem_addr;
        if (mem_req && mem_ready && mem_we) begin
            writes_seen++;
            mem[mem_addr[9:2]] = mem_wdata;
            if (sbq.size() == 0) begin
                check(1'b0, "R4", "unexpected write", mem_addr, 32'h0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(mem_addr == e.a, e.tag, "write address", mem_addr, e.a);
                check(mem_wdata == e.d, e.tag, "write data", mem_wdata, e.d);
            end
        end
    end

    task automatic push(input logic [31:0] a, input logic [31:0] d, input string tag);
        exp_t e;
        e.a = a; e.d = d; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] c,
                            input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
        mem[base[9:2]]       = c;
        mem[base[9:2] + 8'd1] = s;
        mem[base[9:2] + 8'd2] = d;
        mem[base[9:2] + 8'd3] = n;
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] exp, input string tag, input string what);
        logic [31:0] v;
        reg_rd(a, v);
        check(v === exp, tag, what, v, exp);
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        bit gone = 0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 5000 && !gone; i++) begin
            @(negedge clk);
            reg_rd(8'h40, v);
            gone = !v[14];
        end
        check(gone, tag, "channel did not finish", {31'b0, gone}, 32'h1);
    endtask

    task automatic wait_writes(input int n);
        for (int i = 0; i < 5000 && writes_seen < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base, n, w1;
        for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + i;
        mem[253] = 32'hC0DE_0001;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        expect_reg(8'h40, 32'h0, "R1", "control after reset");
        expect_reg(8'h00, 32'h0, "R1", "count after reset");
        expect_reg(8'hA0, 32'h0, "R1", "status after reset");
        check(!irq && !mem_req, "R1", "irq/mem_req after reset", {30'b0, irq, mem_req}, 32'h0);

        // R2: idle writes read back
        reg_wr(8'h10, 32'h1234_5678);
        expect_reg(8'h10, 32'h1234_5678, "R2", "source readback");
        reg_wr(8'h80, 32'h1);
        expect_reg(8'h80, 32'h1, "R2", "mask readback");
        reg_wr(8'h30, 32'h0000_010C);
        expect_reg(8'h30, 32'h0000_010C, "R2", "next readback");

        // R3 R4 R5 R6 R7: single descriptor, memory to fixed device address
        put_desc(32'h100, 32'd16, 32'h200, 32'h3F0, 32'h100);
        for (int i = 0; i < 4; i++) push(32'h3F0, mem[128 + i], "R4");
        reg_wr(8'h40, 32'h0000_3020);
        wait_idle("R7");
        check(sbq.size() == 0, "R4", "writes missing", sbq.size(), 0);
        expect_reg(8'h70, 32'h100, "R3", "current descriptor aligned");
        expect_reg(8'h00, 32'h0, "R4", "count empty");
        expect_reg(8'h10, 32'h210, "R5", "source stepped");
        expect_reg(8'h20, 32'h3F0, "R5", "destination held");
        expect_reg(8'hA0, 32'h1, "R6", "status set");
        check(irq, "R6", "irq with mask", {31'b0, irq}, 32'h1);
        expect_reg(8'h40, 32'h0000_1020, "R7", "stopped, fetch consumed");
        reg_wr(8'hA0, 32'h1);
        expect_reg(8'hA0, 32'h1, "R6", "writing one keeps status");
        reg_wr(8'hA0, 32'h0);
        expect_reg(8'hA0, 32'h0, "R6", "writing zero clears status");
        check(!irq, "R6", "irq after clear", {31'b0, irq}, 32'h0);

        // R7 R9 R5: chained two-descriptor ring, device to memory, then abort
        stall_en = 1;
        reg_wr(8'h80, 32'h0);
        put_desc(32'h140, 32'd8, 32'h3F4, 32'h300, 32'h150);
        put_desc(32'h150, 32'd4, 32'h3F4, 32'h340, 32'h140);
        for (int lap = 0; lap < 3; lap++) begin
            push(32'h300, 32'hC0DE_0001, "R7");
            push(32'h304, 32'hC0DE_0001, "R7");
            push(32'h340, 32'hC0DE_0001, "R7");
        end
        base = writes_seen;
        reg_wr(8'h30, 32'h140);
        reg_wr(8'h40, 32'h0000_3208);
        wait_writes(base + 6);
        check(writes_seen >= base + 6, "R7", "ring did not repeat", writes_seen - base, 6);
        skip_r12 = 1;
        reg_wr(8'h40, 32'h0010_0000);
        reg_rd(8'h40, v);
        check(v[14] == 1'b0 && v[12] == 1'b0, "R9", "active/enable after abort", v, 32'h0);
        check(!mem_req, "R9", "request after abort", {31'b0, mem_req}, 32'h0);
        w1 = writes_seen;
        repeat (20) @(negedge clk);
        skip_r12 = 0;
        check(writes_seen == w1, "R9", "writes after abort", writes_seen, w1);
        sbq.delete();
        expect_reg(8'hA0, 32'h1, "R6", "status set with mask off");
        check(!irq, "R6", "irq masked", {31'b0, irq}, 32'h0);
        reg_wr(8'hA0, 32'h0);

        // R8 R10 R4: pause mid-transfer, ignored writes, resume
        put_desc(32'h180, 32'd32, 32'h200, 32'h300, 32'h180);
        for (int i = 0; i < 8; i++) push(32'h300 + 4 * i, mem[128 + i], "R8");
        base = writes_seen;
        reg_wr(8'h30, 32'h180);
        reg_wr(8'h40, 32'h0000_3000);
        wait_writes(base + 3);
        reg_wr(8'h40, 32'h0);
        repeat (30) @(negedge clk);
        w1 = writes_seen;
        repeat (20) @(negedge clk);
        check(writes_seen == w1, "R8", "beats while paused", writes_seen, w1);
        n = w1 - base;
        check(n >= 3 && n < 8, "R8", "pause beat count", n, 3);
        reg_rd(8'h40, v);
        check(v[14], "R8", "active while paused", v, 32'h4000);
        expect_reg(8'h00, 32'd32 - 4 * n, "R4", "count while paused");
        reg_wr(8'h00, 32'h1000);
        reg_wr(8'h10, 32'hDEAD_0000);
        expect_reg(8'h00, 32'd32 - 4 * n, "R10", "count write ignored");
        expect_reg(8'h10, 32'h200 + 4 * n, "R10", "source write ignored");
        reg_wr(8'h40, 32'h0000_1000);
        wait_idle("R8");
        check(sbq.size() == 0, "R8", "writes missing after resume", sbq.size(), 0);
        expect_reg(8'hA0, 32'h1, "R8", "completion after resume");
        reg_wr(8'hA0, 32'h0);

        // R11: oversized count clipped to MAXB bytes (16 beats)
        put_desc(32'h1C0, 32'h1000, 32'h200, 32'h3F8, 32'h1C0);
        for (int i = 0; i < MAXB / 4; i++) push(32'h3F8, mem[128 + i], "R11");
        base = writes_seen;
        reg_wr(8'h30, 32'h1C0);
        reg_wr(8'h40, 32'h0000_3020);
        wait_idle("R11");
        check(writes_seen - base == MAXB / 4, "R11", "beat count", writes_seen - base, MAXB / 4);
        check(sbq.size() == 0, "R11", "writes missing", sbq.size(), 0);
        expect_reg(8'hA0, 32'h1, "R11", "completion");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule